// File: doc/BRIEF.md
# Vertical Blanking Window Sequencer

This block sits beside the per-line processing stages of a video decoder. It decides, once per line, how the chroma separation, chroma demodulation and luma stages behave while the frame is in vertical blanking. The timing source supplies a strobe at the start of each line and a small identifier for that line. The block uses these to open a vertical window on a fixed line and close it after a programmable number of lines.

Two host control bits set the processing mode. One applies inside the window and the other applies outside the window while the blanking input is low. Sync lines always force the stages off, and so do lines that are outside the window while blanking is high. Every output is registered and changes only on a line-start strobe, so the mode is constant across a line.

Top module: `vbw_sequencer`

## Requirements
- R1: While reset is asserted, and directly after it, `winFlag` is 0, all three mode outputs are 2'b10 (flat for separation, black for demodulation and luma), and `blankOut` is 1.
- R2: No output changes on a clock edge where `lineStrobe` is low, whatever the other inputs do.
- R3: A strobe whose `lineId` equals 2 sets `winFlag` from the next edge and clears the window line count to 0. This also applies when the window is already open, which restarts the window.
- R4: On a strobe with the window open and a `lineId` other than 2, the window closes if the count equals `winEnd`. Otherwise the count increments by one. The window therefore spans `winEnd`+1 lines, counting the opening line.
- R5: On a strobe that leaves the window open for a non-sync line, all three modes become {1'b0, `inWinCtl`}. That is 2'b00 for normal and 2'b01 for simple. `blankOut` becomes 0.
- R6: On a strobe for a non-sync line outside the window with `vBlank` low, all three modes become {1'b0, `outWinCtl`} and `blankOut` becomes 0.
- R7: On a strobe for a non-sync line outside the window with `vBlank` high, all three modes become 2'b10 and `blankOut` becomes 1.
- R8: Sync lines are identifiers 0–1 when `palMode` is 1 and 0–2 when `palMode` is 0. A strobe for a sync line forces all modes to 2'b10 and `blankOut` to 1, with priority over the window and both control bits. The window state still updates as stated in R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-domain clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineStrobe | input | 1 | One-cycle pulse at the start of each line |
| lineId | input | 5 | Identifier of the line that is starting |
| palMode | input | 1 | 1 selects the 625-line standard, 0 selects the 525-line standard |
| vBlank | input | 1 | Vertical blanking from the timing source |
| winEnd | input | 8 | Window line count at which the window closes |
| inWinCtl | input | 1 | Mode control inside the window (0 normal, 1 simple) |
| outWinCtl | input | 1 | Mode control outside the window while not blanking |
| winFlag | output | 1 | Vertical window flag |
| sepMode | output | 2 | Chroma separation mode: 00 normal, 01 simple, 10 flat |
| demodMode | output | 2 | Chroma demodulation mode: 00 normal, 01 simple, 10 black |
| lumaMode | output | 2 | Luma processing mode: 00 normal, 01 simple, 10 black |
| blankOut | output | 1 | High when the line is forced off |

## Verification
A wrong internal state has two main forms. One is a window count that is off by one. The other is a window flag that fails to reopen. Either shows on the first strobe after the window should have closed or opened. At that point `winFlag` and the three mode codes take the wrong control bit, or go to the off code one line early or late. Stray updates between strobes show on the edge right after the inputs change, because the control bits are toggled in the middle of a line. A wrong sync band boundary shows on lines 1, 2 and 3 of each standard, where only the forced-off code is correct.

// File: rtl/vbw_pkg.sv
package vbw_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_SIMPLE = 2'b01,
    MODE_OFF    = 2'b10
  } stageMode_e;

  // Strobes and qualifiers from control to datapath for one line start
  typedef struct packed {
    logic load;      // line start: registers take a new value
    logic winOn;     // window state that applies to the starting line
    logic syncBand;  // starting line is a sync line
  } seqCmd_t;

endpackage

// File: rtl/vbw_band.sv
module vbw_band #(
  parameter int ID_W           = 5,
  parameter int PAL_SYNC_LAST  = 1,
  parameter int NTSC_SYNC_LAST = 2
) (
  input  logic [ID_W-1:0] lineId,
  input  logic            palMode,
  output logic            syncBand
);
  localparam logic [ID_W-1:0] PAL_LIM  = ID_W'(PAL_SYNC_LAST);
  localparam logic [ID_W-1:0] NTSC_LIM = ID_W'(NTSC_SYNC_LAST);

  logic palSync;
  logic ntscSync;

  always_comb begin
    palSync  = (lineId <= PAL_LIM);
    ntscSync = (lineId <= NTSC_LIM);
    syncBand = palMode ? palSync : ntscSync;
  end
endmodule

// File: rtl/vbw_ctrl.sv
module vbw_ctrl
  import vbw_pkg::*;
#(
  parameter int ID_W    = 5,
  parameter int CNT_W   = 8,
  parameter int OPEN_ID = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineStrobe,
  input  logic [ID_W-1:0]  lineId,
  input  logic [CNT_W-1:0] winEnd,
  input  logic             syncBand,
  output seqCmd_t          cmd,
  output logic             winFlag
);
  localparam logic [ID_W-1:0]  OPEN_CODE = ID_W'(OPEN_ID);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

  logic [CNT_W-1:0] winCnt;
  logic [CNT_W-1:0] cntNext;
  logic             winNext;
  logic             openHit;
  logic             endHit;

  always_comb begin
    openHit = lineStrobe && (lineId == OPEN_CODE);
    endHit  = winFlag && (winCnt == winEnd);
    winNext = winFlag;
    cntNext = winCnt;
    if (openHit) begin
      winNext = 1'b1;
      cntNext = '0;
    end else if (lineStrobe && winFlag) begin
      if (endHit) winNext = 1'b0;
      else        cntNext = winCnt + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winFlag <= 1'b0;
      winCnt  <= '0;
    end else begin
      winFlag <= winNext;
      winCnt  <= cntNext;
    end
  end

  always_comb begin
    cmd.load     = lineStrobe;
    cmd.winOn    = winNext;
    cmd.syncBand = syncBand;
  end

  AST_WIN_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (lineStrobe && lineId == OPEN_CODE) |=> (winFlag && winCnt == '0)); // R3

  AST_WIN_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    (lineStrobe && winFlag && winCnt == winEnd && lineId != OPEN_CODE) |=> !winFlag); // R4

  AST_WIN_STILL: assert property (@(posedge clk) disable iff (!rstN)
    !lineStrobe |=> ($stable(winFlag) && $stable(winCnt))); // R2

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (lineStrobe && winFlag && winCnt != winEnd && lineId != OPEN_CODE)
      |=> (winFlag && winCnt == $past(winCnt) + CNT_ONE)); // R4
endmodule

// File: rtl/vbw_datapath.sv
module vbw_datapath
  import vbw_pkg::*;
#(
  parameter int NUM_STAGES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqCmd_t    cmd,
  input  logic       vBlank,
  input  logic       inWinCtl,
  input  logic       outWinCtl,
  output stageMode_e stageMode [NUM_STAGES],
  output logic       blankOut
);
  stageMode_e lineMode;
  logic       lineBlank;

  always_comb begin
    if (cmd.syncBand) begin
      lineMode  = MODE_OFF;
      lineBlank = 1'b1;
    end else if (cmd.winOn) begin
      lineMode  = inWinCtl ? MODE_SIMPLE : MODE_NORMAL;
      lineBlank = 1'b0;
    end else if (!vBlank) begin
      lineMode  = outWinCtl ? MODE_SIMPLE : MODE_NORMAL;
      lineBlank = 1'b0;
    end else begin
      lineMode  = MODE_OFF;
      lineBlank = 1'b1;
    end
  end

  for (genvar s = 0; s < NUM_STAGES; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         stageMode[s] <= MODE_OFF;
      else if (cmd.load) stageMode[s] <= lineMode;
    end

    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !cmd.load |=> $stable(stageMode[s])); // R2
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         blankOut <= 1'b1;
    else if (cmd.load) blankOut <= lineBlank;
  end

  AST_SYNC_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.load && cmd.syncBand) |=> (blankOut && stageMode[0] == MODE_OFF)); // R8

  AST_BLANK_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.load && !cmd.syncBand && !cmd.winOn && vBlank)
      |=> (blankOut && stageMode[NUM_STAGES-1] == MODE_OFF)); // R7

  AST_IN_WIN: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.load && !cmd.syncBand && cmd.winOn)
      |=> (!blankOut && stageMode[0] == ($past(inWinCtl) ? MODE_SIMPLE : MODE_NORMAL))); // R5

  AST_OUT_WIN: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.load && !cmd.syncBand && !cmd.winOn && !vBlank)
      |=> (!blankOut && stageMode[0] == ($past(outWinCtl) ? MODE_SIMPLE : MODE_NORMAL))); // R6
endmodule

// File: rtl/vbw_sequencer.sv
module vbw_sequencer
  import vbw_pkg::*;
#(
  parameter int ID_W  = 5,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineStrobe,
  input  logic [ID_W-1:0]  lineId,
  input  logic             palMode,
  input  logic             vBlank,
  input  logic [CNT_W-1:0] winEnd,
  input  logic             inWinCtl,
  input  logic             outWinCtl,
  output logic             winFlag,
  output logic [1:0]       sepMode,
  output logic [1:0]       demodMode,
  output logic [1:0]       lumaMode,
  output logic             blankOut
);
  localparam int NUM_STAGES = 3;

  logic       syncBand;
  seqCmd_t    cmd;
  stageMode_e stageMode [NUM_STAGES];

  vbw_band #(.ID_W(ID_W)) uBand (
    .lineId   (lineId),
    .palMode  (palMode),
    .syncBand (syncBand)
  );

  vbw_ctrl #(.ID_W(ID_W), .CNT_W(CNT_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .lineStrobe (lineStrobe),
    .lineId     (lineId),
    .winEnd     (winEnd),
    .syncBand   (syncBand),
    .cmd        (cmd),
    .winFlag    (winFlag)
  );

  vbw_datapath #(.NUM_STAGES(NUM_STAGES)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .vBlank    (vBlank),
    .inWinCtl  (inWinCtl),
    .outWinCtl (outWinCtl),
    .stageMode (stageMode),
    .blankOut  (blankOut)
  );

  always_comb begin
    sepMode   = stageMode[0];
    demodMode = stageMode[1];
    lumaMode  = stageMode[2];
  end

  AST_MODES_AGREE: assert property (@(posedge clk) disable iff (!rstN)
    (blankOut == (sepMode == 2'b10)) && (sepMode == lumaMode)); // R5 R7
endmodule

// File: tb/tb_vbw_sequencer.sv
`timescale 1ns/1ps
module tb_vbw_sequencer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineStrobe = 1'b0;
  logic [4:0] lineId = '0;
  logic       palMode = 1'b1;
  logic       vBlank = 1'b0;
  logic [7:0] winEnd = '0;
  logic       inWinCtl = 1'b0;
  logic       outWinCtl = 1'b0;
  logic       winFlag;
  logic [1:0] sepMode, demodMode, lumaMode;
  logic       blankOut;

  int tests = 0;
  int fails = 0;

  // reference model state
  int    mWin = 0;
  int    mCnt = 0;
  int    mMode = 2;
  int    mBlank = 1;
  string mTag = "R1";

  always #10 clk = ~clk;

  vbw_sequencer dut (
    .clk(clk), .rstN(rstN), .lineStrobe(lineStrobe), .lineId(lineId),
    .palMode(palMode), .vBlank(vBlank), .winEnd(winEnd), .inWinCtl(inWinCtl),
    .outWinCtl(outWinCtl), .winFlag(winFlag), .sepMode(sepMode),
    .demodMode(demodMode), .lumaMode(lumaMode), .blankOut(blankOut)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mWin = 0; mCnt = 0; mMode = 2; mBlank = 1; mTag = "R1";
    end else if (!lineStrobe) begin
      mTag = "R2";
    end else begin
      int id;
      bit sync;
      id = int'(lineId);
      if (id == 2) begin
        mWin = 1; mCnt = 0;
      end else if (mWin == 1) begin
        if (mCnt == int'(winEnd)) mWin = 0;
        else mCnt = (mCnt + 1) % 256;
      end
      sync = palMode ? (id <= 1) : (id <= 2);
      if (sync) begin
        mMode = 2; mBlank = 1; mTag = "R8";
      end else if (mWin == 1) begin
        mMode = inWinCtl ? 1 : 0; mBlank = 0; mTag = "R5 R3 R4";
      end else if (!vBlank) begin
        mMode = outWinCtl ? 1 : 0; mBlank = 0; mTag = "R6 R4";
      end else begin
        mMode = 2; mBlank = 1; mTag = "R7 R4";
      end
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check(mTag, "winFlag",   int'(winFlag),   mWin);
    check(mTag, "sepMode",   int'(sepMode),   mMode);
    check(mTag, "demodMode", int'(demodMode), mMode);
    check(mTag, "lumaMode",  int'(lumaMode),  mMode);
    check(mTag, "blankOut",  int'(blankOut),  mBlank);
  endtask

  task automatic tick();
    @(negedge clk);
    compareAll();
  endtask

  // one line: strobe cycle, then idle cycles with control bits toggled (R2)
  task automatic doLine(input int id, input bit vb, input bit ci, input bit co, input int idle);
    tick();
    lineStrobe = 1'b1; lineId = 5'(id); vBlank = vb; inWinCtl = ci; outWinCtl = co;
    tick();
    lineStrobe = 1'b0;
    for (int k = 0; k < idle; k++) begin
      tick();
      inWinCtl = ~inWinCtl; outWinCtl = ~outWinCtl; vBlank = ~vBlank;
      lineId = 5'(2);
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int ends [4] = '{3, 0, 7, 1};
    // R1: reset values while reset is held
    repeat (3) tick();
    check("R1", "reset sepMode", int'(sepMode), 2);
    check("R1", "reset blankOut", int'(blankOut), 1);
    check("R1", "reset winFlag", int'(winFlag), 0);
    rstN = 1'b1;
    repeat (2) tick();
    for (int std = 0; std < 2; std++) begin
      palMode = (std == 0);
      for (int f = 0; f < 4; f++) begin
        winEnd = 8'(ends[f]);
        for (int id = 0; id < 28; id++) begin
          doLine(id % 32, (f % 2 == 0) ? (id < 12) : (id < 5), f[0], f[1], 1 + (id % 3));
        end
      end
    end
    // R3: reopen while already open restarts the window
    palMode = 1'b1; winEnd = 8'd4;
    for (int id = 0; id < 10; id++) doLine((id == 5) ? 2 : id, 1'b1, 1'b1, 1'b0, 1);
    // mixed pattern
    for (int n = 0; n < 400; n++) begin
      if (n % 50 == 0) begin
        palMode = $urandom_range(0, 1);
        winEnd = 8'($urandom_range(0, 9));
      end
      doLine($urandom_range(0, 31), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), $urandom_range(0, 3));
    end
    tick();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule